// File: doc/BRIEF.md
# Keyed Configuration Port Front End

This block places a two-byte window on a byte-wide host I/O bus. The window is a register-select port at the base address and a value port one address above it. Behind them sits a configuration space, but the space stays closed until the host has unlocked it by writing a magic byte twice in a row to the select port. A different magic byte written to the select port closes the space again. A static input chooses which of two key pairs is in force.

Once the space is open, a select-port write names a register and value-port accesses act on it. Two registers are held locally: a device-number register that picks one of several logical devices, and a read-only identity byte. System software reads the identity byte to probe for the part, and a value of 0xFF means that nothing answers. Every register number from 0x30 upward is passed to the chosen logical device through a strobed read/write side interface that is combinational and has no wait states. The function blocks behind that interface are not part of this block.

Top module: `cfgp_port_top`

## Requirements
- R1: After reset the space is locked, the latched register number is 0x00 and the device number is 0. While locked, a read of either port returns 0xFF, and so does any read that does not hit the two ports.
- R2: The space opens only on the clock edge of the second of two consecutive select-port writes of the enter key (0x87 when `alt_keys` is 0). A single enter key leaves value-port reads at 0xFF.
- R3: Any other select-port write made after one enter key (for example 0x55) clears the unlock progress, so the next enter key counts as the first again. Value-port accesses do not affect the progress.
- R4: While open, a select-port write of the exit key (0xAA when `alt_keys` is 0) locks the space, and that byte is not taken as a register number.
- R5: With `alt_keys` = 1 the enter key is 0x88 and the exit key is 0xBB. The default keys then carry no special meaning: 0x87 twice does not open the space and, while open, 0xAA is latched as an ordinary register number.
- R6: While open, any other select-port write latches a register number, including the enter key itself. A select-port read returns it while open. The latched number is kept across a lock and an unlock.
- R7: Register 0x07 holds the logical device number. A write keeps the low `$clog2(NUM_LDN)` bits, and a read returns them zero-extended.
- R8: Register 0x20 reads as the `CHIP_ID` parameter, and writes to it have no effect.
- R9: With a register number of 0x30 or above, a value-port write raises `dev_wr` in the same cycle with `dev_sel` = device number, `dev_reg` = register number and `dev_wdata` = host byte. A value-port read raises `dev_rd` and returns `dev_rdata`.
- R10: While locked, value-port writes are ignored. They raise no device strobe and leave the device number unchanged.
- R11: Accesses to any address other than the base address and base+1 are ignored. They make no key progress, do not lock, and raise no strobe.
- R12: Register numbers below 0x30 other than 0x07 and 0x20 read as 0x00, ignore writes and never raise a device strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alt_keys | input | 1 | Selects the alternate key pair (static) |
| io_addr | input | ADDR_W | Host I/O address |
| io_wr | input | 1 | Host write strobe, one cycle per access |
| io_rd | input | 1 | Host read strobe, one cycle per access |
| io_wdata | input | 8 | Host write byte |
| io_rdata | output | 8 | Host read byte, valid while `io_rd` is high |
| cfg_open | output | 1 | Configuration space is unlocked |
| dev_wr | output | 1 | Write strobe to the logical-device side |
| dev_rd | output | 1 | Read strobe to the logical-device side |
| dev_sel | output | $clog2(NUM_LDN) | Selected logical device number |
| dev_reg | output | 8 | Register number forwarded to the device |
| dev_wdata | output | 8 | Byte forwarded with `dev_wr` |
| dev_rdata | input | 8 | Byte returned by the selected device |

## Verification
The bench builds the block with its base at 0x4E, with sixteen logical devices and with an identity byte of 0x5A. Because the base is 0x4E, the other usual base 0x2E becomes a foreign address, so key bytes sent there can be shown to have no effect. Sixteen devices give a 4-bit device field, which shows the upper-bit truncation of the 0x07 register. The identity byte differs from 0x00 and 0xFF, so a read of it cannot be mistaken for an unmapped register or for a locked port.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

  typedef enum logic [1:0] {
    KEY_LOCKED = 2'd0,
    KEY_HALF   = 2'd1,
    KEY_OPEN   = 2'd2
  } key_state_e;

  localparam logic [7:0] REG_LDN    = 8'h07;
  localparam logic [7:0] REG_ID     = 8'h20;
  localparam logic [7:0] DEV_FIRST  = 8'h30;
  localparam logic [7:0] IDLE_BYTE  = 8'hFF;

  // Key selection for the two supported pairs.
  function automatic logic [7:0] enter_key(input logic alt);
    return alt ? 8'h88 : 8'h87;
  endfunction

  function automatic logic [7:0] exit_key(input logic alt);
    return alt ? 8'hBB : 8'hAA;
  endfunction

  // Register numbers at or above DEV_FIRST belong to a logical device.
  function automatic logic is_dev_reg(input logic [7:0] idx);
    return idx >= DEV_FIRST;
  endfunction

endpackage

// File: rtl/cfgp_key_fsm.sv
module cfgp_key_fsm
  import cfgp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       alt_keys,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       cfg_open,
  output logic       idx_load
);

  key_state_e st, st_nxt;
  logic [7:0] k_enter, k_exit;
  logic       is_enter, is_exit;

  assign k_enter  = enter_key(alt_keys);
  assign k_exit   = exit_key(alt_keys);
  assign is_enter = (wdata == k_enter);
  assign is_exit  = (wdata == k_exit);

  always_comb begin
    st_nxt = st;
    if (idx_wr) begin
      unique case (st)
        KEY_LOCKED: st_nxt = is_enter ? KEY_HALF : KEY_LOCKED;
        KEY_HALF:   st_nxt = is_enter ? KEY_OPEN : KEY_LOCKED;
        KEY_OPEN:   st_nxt = is_exit  ? KEY_LOCKED : KEY_OPEN;
        default:    st_nxt = KEY_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= KEY_LOCKED;
    else        st <= st_nxt;
  end

  assign cfg_open = (st == KEY_OPEN);
  // Event: a select-port byte is taken as a register number.
  assign idx_load = cfg_open && idx_wr && !is_exit;

  // R2: two consecutive enter keys open the space
  p_second_key_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == KEY_HALF && idx_wr && wdata == enter_key(alt_keys)) |=> cfg_open);
  // R2: the space is never open one edge after being fully locked
  p_no_single_key_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == KEY_LOCKED) |=> !cfg_open);
  // R3: a stray byte after one key drops the progress
  p_stray_byte_relocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == KEY_HALF && idx_wr && wdata != enter_key(alt_keys)) |=> (st == KEY_LOCKED));
  // R4: the exit key always locks
  p_exit_relocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && idx_wr && wdata == exit_key(alt_keys)) |=> !cfg_open);

endmodule

// File: rtl/cfgp_cfg_regs.sv
module cfgp_cfg_regs
  import cfgp_pkg::*;
#(
  parameter logic [7:0] CHIP_ID = 8'hA5,
  parameter int         LDN_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_open,
  input  logic             idx_load,
  input  logic             dat_wr,
  input  logic [7:0]       wdata,
  output logic [7:0]       index,
  output logic [LDN_W-1:0] ldn,
  output logic [7:0]       local_rdata
);

  logic ldn_we;

  assign ldn_we = cfg_open && dat_wr && (index == REG_LDN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      index <= 8'h00;
      ldn   <= '0;
    end else begin
      if (idx_load) index <= wdata;
      if (ldn_we)   ldn   <= wdata[LDN_W-1:0];
    end
  end

  always_comb begin
    unique case (index)
      REG_LDN: local_rdata = 8'(ldn);
      REG_ID:  local_rdata = CHIP_ID;
      default: local_rdata = 8'h00;
    endcase
  end

  // R10: the device number cannot move while the space is locked
  p_ldn_frozen_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |=> $stable(ldn));
  // R6: a load event places the host byte in the register number
  p_index_takes_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
    idx_load |=> (index == $past(wdata)));
  // R6: the register number holds without a load event
  p_index_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_load |=> $stable(index));

endmodule

// File: rtl/cfgp_dev_route.sv
module cfgp_dev_route
  import cfgp_pkg::*;
#(
  parameter int LDN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_open,
  input  logic             dat_wr,
  input  logic             dat_rd,
  input  logic [7:0]       index,
  input  logic [LDN_W-1:0] ldn,
  input  logic [7:0]       wdata,
  output logic             dev_wr,
  output logic             dev_rd,
  output logic [LDN_W-1:0] dev_sel,
  output logic [7:0]       dev_reg,
  output logic [7:0]       dev_wdata,
  output logic             route_hit
);

  assign route_hit = cfg_open && is_dev_reg(index);
  assign dev_wr    = route_hit && dat_wr;
  assign dev_rd    = route_hit && dat_rd;
  assign dev_sel   = ldn;
  assign dev_reg   = index;
  assign dev_wdata = wdata;

  // R10: no device strobe while locked
  p_strobe_needs_open_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_wr || dev_rd) |-> cfg_open);
  // R12: no device strobe for a local register number
  p_strobe_range_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_wr || dev_rd) |-> (dev_reg >= 8'h30));

endmodule

// File: rtl/cfgp_port_top.sv
module cfgp_port_top
  import cfgp_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h002E,
  parameter logic [7:0]        CHIP_ID   = 8'hA5,
  parameter int                NUM_LDN   = 16,
  localparam int               LDN_W     = $clog2(NUM_LDN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alt_keys,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              cfg_open,
  output logic              dev_wr,
  output logic              dev_rd,
  output logic [LDN_W-1:0]  dev_sel,
  output logic [7:0]        dev_reg,
  output logic [7:0]        dev_wdata,
  input  logic [7:0]        dev_rdata
);

  localparam logic [ADDR_W-1:0] DATA_ADDR = BASE_ADDR + 1'b1;

  logic hit_idx, hit_dat;
  logic idx_wr, idx_rd, dat_wr, dat_rd;
  logic idx_load, route_hit;
  logic [7:0] index, local_rdata;
  logic [LDN_W-1:0] ldn;

  assign hit_idx = (io_addr == BASE_ADDR);
  assign hit_dat = (io_addr == DATA_ADDR);
  assign idx_wr  = io_wr && hit_idx;
  assign idx_rd  = io_rd && hit_idx;
  assign dat_wr  = io_wr && hit_dat;
  assign dat_rd  = io_rd && hit_dat;

  cfgp_key_fsm u_keys (
    .clk      (clk),
    .rst_n    (rst_n),
    .alt_keys (alt_keys),
    .idx_wr   (idx_wr),
    .wdata    (io_wdata),
    .cfg_open (cfg_open),
    .idx_load (idx_load)
  );

  cfgp_cfg_regs #(
    .CHIP_ID (CHIP_ID),
    .LDN_W   (LDN_W)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_open    (cfg_open),
    .idx_load    (idx_load),
    .dat_wr      (dat_wr),
    .wdata       (io_wdata),
    .index       (index),
    .ldn         (ldn),
    .local_rdata (local_rdata)
  );

  cfgp_dev_route #(
    .LDN_W (LDN_W)
  ) u_route (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_open  (cfg_open),
    .dat_wr    (dat_wr),
    .dat_rd    (dat_rd),
    .index     (index),
    .ldn       (ldn),
    .wdata     (io_wdata),
    .dev_wr    (dev_wr),
    .dev_rd    (dev_rd),
    .dev_sel   (dev_sel),
    .dev_reg   (dev_reg),
    .dev_wdata (dev_wdata),
    .route_hit (route_hit)
  );

  always_comb begin
    io_rdata = IDLE_BYTE;
    if (cfg_open) begin
      if (idx_rd)      io_rdata = index;
      else if (dat_rd) io_rdata = route_hit ? dev_rdata : local_rdata;
    end
  end

  // R1: a locked space answers every read with 0xFF
  p_locked_reads_ff_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_open && io_rd) |-> (io_rdata == 8'hFF));
  // R11: a foreign address never changes the lock state
  p_foreign_no_lock_change_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_idx && !hit_dat) |=> $stable(cfg_open));

endmodule

// File: tb/cfgp_port_top_test.sv
module cfgp_port_top_test;

  localparam int          ADDR_W = 16;
  localparam logic [15:0] BASE   = 16'h004E;
  localparam logic [15:0] IDX    = 16'h004E;
  localparam logic [15:0] DAT    = 16'h004F;
  localparam logic [15:0] OTHER  = 16'h002E;
  localparam logic [7:0]  CHIP   = 8'h5A;
  localparam int          NLDN   = 16;
  localparam int          LW     = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alt_keys = 1'b0;
  logic [15:0] io_addr = '0;
  logic io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0] io_wdata = '0;
  logic [7:0] io_rdata;
  logic cfg_open, dev_wr, dev_rd;
  logic [LW-1:0] dev_sel;
  logic [7:0] dev_reg, dev_wdata;
  logic [7:0] dev_rdata = 8'h00;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cfgp_port_top #(
    .ADDR_W (ADDR_W), .BASE_ADDR (BASE), .CHIP_ID (CHIP), .NUM_LDN (NLDN)
  ) uut (
    .clk (clk), .rst_n (rst_n), .alt_keys (alt_keys), .io_addr (io_addr),
    .io_wr (io_wr), .io_rd (io_rd), .io_wdata (io_wdata), .io_rdata (io_rdata),
    .cfg_open (cfg_open), .dev_wr (dev_wr), .dev_rd (dev_rd), .dev_sel (dev_sel),
    .dev_reg (dev_reg), .dev_wdata (dev_wdata), .dev_rdata (dev_rdata)
  );

  // {op, req, addr, data, expect}; op 0 = write, 1 = read and compare
  localparam int NV = 30;
  localparam logic [40:0] VEC [NV] = '{
    {1'b1, 8'd1,  DAT, 8'h00, 8'hFF}, // R1 locked value read
    {1'b1, 8'd6,  IDX, 8'h00, 8'hFF}, // R6 locked select read
    {1'b0, 8'd2,  IDX, 8'h87, 8'h00}, // R2 first key
    {1'b1, 8'd2,  DAT, 8'h00, 8'hFF}, // R2 one key is not enough
    {1'b0, 8'd2,  IDX, 8'h87, 8'h00}, // R2 second key
    {1'b1, 8'd6,  IDX, 8'h00, 8'h00}, // R6 register number from reset
    {1'b0, 8'd8,  IDX, 8'h20, 8'h00},
    {1'b1, 8'd8,  DAT, 8'h00, CHIP }, // R8 identity byte
    {1'b0, 8'd8,  DAT, 8'h11, 8'h00},
    {1'b1, 8'd8,  DAT, 8'h00, CHIP }, // R8 write ignored
    {1'b0, 8'd7,  IDX, 8'h07, 8'h00},
    {1'b0, 8'd7,  DAT, 8'hF3, 8'h00},
    {1'b1, 8'd7,  DAT, 8'h00, 8'h03}, // R7 truncated device number
    {1'b0, 8'd6,  IDX, 8'h87, 8'h00},
    {1'b1, 8'd6,  IDX, 8'h00, 8'h87}, // R6 enter key latched while open
    {1'b0, 8'd12, IDX, 8'h2C, 8'h00},
    {1'b0, 8'd12, DAT, 8'h77, 8'h00},
    {1'b1, 8'd12, DAT, 8'h00, 8'h00}, // R12 unmapped local register
    {1'b0, 8'd4,  IDX, 8'hAA, 8'h00},
    {1'b1, 8'd4,  DAT, 8'h00, 8'hFF}, // R4 locked again
    {1'b1, 8'd4,  IDX, 8'h00, 8'hFF}, // R4
    {1'b0, 8'd3,  IDX, 8'h87, 8'h00},
    {1'b0, 8'd3,  IDX, 8'h55, 8'h00},
    {1'b0, 8'd3,  IDX, 8'h87, 8'h00},
    {1'b1, 8'd3,  DAT, 8'h00, 8'hFF}, // R3 progress was cleared
    {1'b0, 8'd3,  IDX, 8'h87, 8'h00},
    {1'b1, 8'd6,  IDX, 8'h00, 8'h2C}, // R6 kept over lock, exit key not taken
    {1'b0, 8'd7,  IDX, 8'h07, 8'h00},
    {1'b1, 8'd7,  DAT, 8'h00, 8'h03}, // R7 device number kept
    {1'b0, 8'd4,  IDX, 8'hAA, 8'h00}
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(posedge clk); #1 io_wr = 1'b0;
  endtask

  // write with the device strobe observed mid-cycle
  task automatic wr_obs(input logic [15:0] a, input logic [7:0] d, input string req,
                        input logic exp_wr);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    #2 check(req, "dev_wr", int'(dev_wr), int'(exp_wr));
    @(posedge clk); #1 io_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] e, input string req);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #2 check(req, "io_rdata", int'(io_rdata), int'(e));
    @(posedge clk); #1 io_rd = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    #2 check("R1", "cfg_open", int'(cfg_open), 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][40]) rd(VEC[i][31:16], VEC[i][7:0], $sformatf("R%0d", VEC[i][39:32]));
      else            wr(VEC[i][31:16], VEC[i][15:8]);
    end

    // R10: locked value write ignored; register number is 0x07 here
    wr_obs(DAT, 8'h05, "R10", 1'b0);
    wr(IDX, 8'h87); wr(IDX, 8'h87);
    rd(DAT, 8'h03, "R10");

    // R9: device routing
    wr(IDX, 8'h07); wr(DAT, 8'h05);
    wr(IDX, 8'h35);
    @(negedge clk);
    io_addr = DAT; io_wdata = 8'h9C; io_wr = 1'b1;
    #2;
    check("R9", "dev_wr", int'(dev_wr), 1);
    check("R9", "dev_sel", int'(dev_sel), 5);
    check("R9", "dev_reg", int'(dev_reg), 8'h35);
    check("R9", "dev_wdata", int'(dev_wdata), 8'h9C);
    @(posedge clk); #1 io_wr = 1'b0;
    dev_rdata = 8'h3D;
    @(negedge clk);
    io_addr = DAT; io_rd = 1'b1;
    #2;
    check("R9", "dev_rd", int'(dev_rd), 1);
    check("R9", "io_rdata", int'(io_rdata), 8'h3D);
    @(posedge clk); #1 io_rd = 1'b0;
    wr(IDX, 8'h30);
    wr_obs(DAT, 8'h01, "R9", 1'b1);
    // R12: just below the device range
    wr(IDX, 8'h2F);
    wr_obs(DAT, 8'h01, "R12", 1'b0);

    // R11: foreign address
    wr(OTHER, 8'hAA);
    rd(IDX, 8'h2F, "R11");
    wr(IDX, 8'h30);
    wr_obs(OTHER + 16'd1, 8'h44, "R11", 1'b0);
    wr(IDX, 8'hAA);
    wr(OTHER, 8'h87); wr(OTHER, 8'h87);
    rd(DAT, 8'hFF, "R11");

    // R5: alternate key pair
    alt_keys = 1'b1;
    wr(IDX, 8'h87); wr(IDX, 8'h87);
    rd(DAT, 8'hFF, "R5");
    wr(IDX, 8'h88); wr(IDX, 8'h88);
    #2 check("R5", "cfg_open", int'(cfg_open), 1);
    wr(IDX, 8'hAA);
    rd(IDX, 8'hAA, "R5");
    wr(IDX, 8'hBB);
    rd(IDX, 8'hFF, "R5");
    alt_keys = 1'b0;

    // R1: reset while open clears state
    wr(IDX, 8'h87); wr(IDX, 8'h87);
    wr(IDX, 8'h44);
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1 rst_n = 1'b1;
    rd(IDX, 8'hFF, "R1");
    wr(IDX, 8'h87); wr(IDX, 8'h87);
    rd(IDX, 8'h00, "R1");
    wr(IDX, 8'h07);
    rd(DAT, 8'h00, "R1");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule